// File: doc/BRIEF.md
# Pin Interrupt Sense Unit

This block watches a vector of already-synchronized pin inputs and turns chosen transitions or levels on each pin into sticky interrupt status bits. Every pin has its own sense setting. The default setting reports any change on the pin. When a pin's alternate-sense bit is set, two more per-pin bits choose edge or level detection and the polarity. Falling edges and low levels use polarity 0. Rising edges and high levels use polarity 1.

All per-pin settings are written through one command port. A command code names a set action or a clear action on one setting vector. The data word selects the pins that the command touches. Status bits collect events until software reads them. The read strobe clears the status. The status is ANDed with a per-pin mask, and the result is reduced to one interrupt line. Input filtering and pad control are handled elsewhere.

Top module: `pinsense_unit`

## Requirements
- R1: After reset the mask, alternate-sense, kind and polarity vectors are all zero, the status is zero and `irq` is low. No edge is reported on the first clock after reset is released, whatever level the pins hold.
- R2: When a pin's alternate-sense bit is 0, a rising or a falling transition between two consecutive clocks sets its status bit. Its kind and polarity bits have no effect.
- R3: When alternate-sense is 1 and kind is 0 (edge), polarity 0 reports only falling transitions and polarity 1 reports only rising transitions.
- R4: When alternate-sense is 1 and kind is 1 (level), polarity 0 reports a low pin and polarity 1 reports a high pin. The status bit is set again on every clock for as long as the level persists, including the clock right after a read.
- R5: With `wrEn` high, `wrCmd` selects one action: 0 mask on, 1 mask off, 2 alternate-sense on, 3 alternate-sense off, 4 kind edge (kind to 0), 5 kind level (kind to 1), 6 polarity low/falling (to 0), 7 polarity high/rising (to 1). Only the pins whose `wrData` bit is 1 change. A new setting takes effect from the next clock.
- R6: `statusRd` shows the status vector. When `rdEn` is high at a clock edge, the status is cleared at that edge. An event detected on that same edge is still kept.
- R7: A status bit stays set until a read clears it, even after its condition has gone away.
- R8: `irq` is high exactly when some pin has both its status bit and its mask bit set.
- R9: Command codes 8 to 15 change no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Synchronized pin levels |
| wrEn | input | 1 | Command valid |
| wrCmd | input | 4 | Command code (see R5) |
| wrData | input | NUM_PINS | Pin select for the command |
| rdEn | input | 1 | Status read; clears the status at the clock edge |
| statusRd | output | NUM_PINS | Sticky status vector |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong setting bit does not show up at once. It shows up as a missing or extra status bit on the clock after the first pin activity that the right and wrong modes treat differently. A command that writes the wrong pin or the wrong vector can therefore stay hidden until that pin toggles. If the mask is wrong, `irq` differs from the expected value as soon as status appears on that pin. A broken clear or a broken sticky path shows in `statusRd` one clock after the read. Level mode gives the quickest sign, because it must report again on the very next clock.

// File: rtl/pinsense_pkg.sv
package pinsense_pkg;
  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_MASK_ON    = 4'd0;
  localparam logic [CMD_W-1:0] CMD_MASK_OFF   = 4'd1;
  localparam logic [CMD_W-1:0] CMD_ALT_ON     = 4'd2;
  localparam logic [CMD_W-1:0] CMD_ALT_OFF    = 4'd3;
  localparam logic [CMD_W-1:0] CMD_KIND_EDGE  = 4'd4;
  localparam logic [CMD_W-1:0] CMD_KIND_LEVEL = 4'd5;
  localparam logic [CMD_W-1:0] CMD_POL_LOW    = 4'd6;
  localparam logic [CMD_W-1:0] CMD_POL_HIGH   = 4'd7;

  typedef struct packed {
    logic maskOn;
    logic maskOff;
    logic altOn;
    logic altOff;
    logic kindEdge;
    logic kindLevel;
    logic polLow;
    logic polHigh;
    logic statusClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/pinsense_ctrl.sv
module pinsense_ctrl
  import pinsense_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrCmd,
  input  logic             rdEn,
  output ctrlStrobe_t      strb
);
  always_comb begin
    strb           = '0;
    strb.statusClr = rdEn;
    if (wrEn) begin
      case (wrCmd)
        CMD_MASK_ON:    strb.maskOn    = 1'b1;
        CMD_MASK_OFF:   strb.maskOff   = 1'b1;
        CMD_ALT_ON:     strb.altOn     = 1'b1;
        CMD_ALT_OFF:    strb.altOff    = 1'b1;
        CMD_KIND_EDGE:  strb.kindEdge  = 1'b1;
        CMD_KIND_LEVEL: strb.kindLevel = 1'b1;
        CMD_POL_LOW:    strb.polLow    = 1'b1;
        CMD_POL_HIGH:   strb.polHigh   = 1'b1;
        default: ;
      endcase
    end
  end

  // R5/R9: one command drives at most one setting strobe
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.maskOn, strb.maskOff, strb.altOn, strb.altOff,
              strb.kindEdge, strb.kindLevel, strb.polLow, strb.polHigh}));

  // R9: codes above the defined range raise no strobe
  a_r9_unused_code: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrCmd[CMD_W-1]) |->
      !(|{strb.maskOn, strb.maskOff, strb.altOn, strb.altOff,
          strb.kindEdge, strb.kindLevel, strb.polLow, strb.polHigh}));
endmodule

// File: rtl/pinsense_dp.sv
module pinsense_dp
  import pinsense_pkg::*;
#(
  parameter int NUM_PINS = 32
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] wrData,
  input  ctrlStrobe_t         strb,
  output logic [NUM_PINS-1:0] statusRd,
  output logic                irq
);
  localparam int PW = NUM_PINS;

  logic [PW-1:0] maskQ, altQ, kindQ, polQ;
  logic [PW-1:0] prevPin, statusQ, evt;
  logic          primed;

  function automatic logic [PW-1:0] setClr(input logic [PW-1:0] cur,
                                           input logic setS, input logic clrS,
                                           input logic [PW-1:0] sel);
    logic [PW-1:0] r;
    r = cur;
    if (setS) r = r | sel;
    if (clrS) r = r & ~sel;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      altQ    <= '0;
      kindQ   <= '0;
      polQ    <= '0;
      prevPin <= '0;
      statusQ <= '0;
      primed  <= 1'b0;
    end else begin
      maskQ   <= setClr(maskQ, strb.maskOn,    strb.maskOff,  wrData);
      altQ    <= setClr(altQ,  strb.altOn,     strb.altOff,   wrData);
      kindQ   <= setClr(kindQ, strb.kindLevel, strb.kindEdge, wrData);
      polQ    <= setClr(polQ,  strb.polHigh,   strb.polLow,   wrData);
      prevPin <= pinIn;
      primed  <= 1'b1;
      statusQ <= (strb.statusClr ? '0 : statusQ) | evt;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_pin
    logic rise, fall;
    assign rise = primed & pinIn[i] & ~prevPin[i];
    assign fall = primed & ~pinIn[i] & prevPin[i];

    always_comb begin
      if (!altQ[i])     evt[i] = rise | fall;
      else if (kindQ[i]) evt[i] = (pinIn[i] == polQ[i]);
      else              evt[i] = polQ[i] ? rise : fall;
    end

    a_r2_both_edges: assert property (@(posedge clk) disable iff (!rstN)
      (primed && !altQ[i] && (pinIn[i] != prevPin[i])) |=> statusQ[i]);

    a_r3_no_wrong_edge: assert property (@(posedge clk) disable iff (!rstN)
      (altQ[i] && !kindQ[i] && polQ[i] && !pinIn[i] && !statusQ[i]) |=> !statusQ[i]);

    a_r4_level_refire: assert property (@(posedge clk) disable iff (!rstN)
      (altQ[i] && kindQ[i] && (pinIn[i] == polQ[i])) |=> statusQ[i]);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !strb.statusClr) |=> statusQ[i]);
  end

  assign statusRd = statusQ;
  assign irq      = |(statusQ & maskQ);

  a_r1_first_cycle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!primed && !(|altQ)) |=> (statusQ == '0));
endmodule

// File: rtl/pinsense_unit.sv
module pinsense_unit
  import pinsense_pkg::*;
#(
  parameter int NUM_PINS = 32
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic [3:0]          wrCmd,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic                rdEn,
  output logic [NUM_PINS-1:0] statusRd,
  output logic                irq
);
  ctrlStrobe_t strb;

  pinsense_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCmd(wrCmd), .rdEn(rdEn), .strb(strb)
  );

  pinsense_dp #(.NUM_PINS(NUM_PINS)) i_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrData(wrData), .strb(strb),
    .statusRd(statusRd), .irq(irq)
  );
endmodule

// File: tb/test_pinsense_unit.sv
module test_pinsense_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] pinIn = '1;
  logic wrEn = 1'b0;
  logic [3:0] wrCmd = '0;
  logic [N-1:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [N-1:0] statusRd;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinsense_unit #(.NUM_PINS(N)) i_pinsense_unit (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrCmd(wrCmd),
    .wrData(wrData), .rdEn(rdEn), .statusRd(statusRd), .irq(irq)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // bench reference state
  logic [N-1:0] mMask = '0, mAlt = '0, mKind = '0, mPol = '0;
  logic [N-1:0] mStat = '0, mPrev = '0;
  logic mPrimed = 1'b0;

  function automatic logic [N-1:0] expEvents(logic [N-1:0] p, logic [N-1:0] pv,
      logic [N-1:0] alt, logic [N-1:0] kind, logic [N-1:0] pol, logic prim);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      logic up, dn;
      up = prim && p[i] && !pv[i];
      dn = prim && !p[i] && pv[i];
      if (!alt[i]) e[i] = up || dn;
      else if (kind[i]) e[i] = (p[i] == pol[i]);
      else e[i] = pol[i] ? up : dn;
    end
    return e;
  endfunction

  function automatic logic [N-1:0] applyCmd(logic [N-1:0] cur, logic [3:0] c,
      logic [3:0] setCode, logic [3:0] clrCode, logic [N-1:0] d);
    if (c == setCode) return cur | d;
    if (c == clrCode) return cur & ~d;
    return cur;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at the current negedge, advance, compare at next negedge
  task automatic step(logic [N-1:0] p, logic we, logic [3:0] c, logic [N-1:0] d,
                      logic rd, string tag);
    logic [N-1:0] ev;
    pinIn = p; wrEn = we; wrCmd = c; wrData = d; rdEn = rd;
    ev = expEvents(p, mPrev, mAlt, mKind, mPol, mPrimed);
    @(posedge clk);
    #1;
    mStat = (rd ? '0 : mStat) | ev;
    if (we) begin
      mMask = applyCmd(mMask, c, 4'd0, 4'd1, d);
      mAlt  = applyCmd(mAlt,  c, 4'd2, 4'd3, d);
      mKind = applyCmd(mKind, c, 4'd5, 4'd4, d);
      mPol  = applyCmd(mPol,  c, 4'd7, 4'd6, d);
    end
    mPrev = p;
    mPrimed = 1'b1;
    @(negedge clk);
    check(tag, statusRd, mStat);
    check({tag, " irq"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(mStat & mMask)});
  endtask

  task automatic cmd(logic [3:0] c, logic [N-1:0] d, string tag);
    step(pinIn, 1'b1, c, d, 1'b0, tag);
  endtask

  task automatic idle(logic [N-1:0] p, logic rd, string tag);
    step(p, 1'b0, 4'd0, '0, rd, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] p;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset status", statusRd, '0);
    check("R1 reset irq", {{(N-1){1'b0}}, irq}, '0);
    rstN = 1'b1;
    p = '1;
    idle(p, 1'b0, "R1 first cycle quiet");
    idle(p, 1'b0, "R1 idle");

    cmd(4'd0, 32'h0000_000F, "R5 mask on low nibble");
    cmd(4'd5, 32'hFFFF_FFFF, "R2 kind ignored");
    p[0] = 1'b0; idle(p, 1'b0, "R2 falling with alt off");
    idle(p, 1'b1, "R6 read clears");
    p[0] = 1'b1; idle(p, 1'b0, "R2 rising with alt off");
    idle(p, 1'b1, "R6 read clears again");
    cmd(4'd4, 32'hFFFF_FFFF, "R5 kind back to edge");

    cmd(4'd10, 32'hFFFF_FFFF, "R9 unused code");
    p[8] = 1'b0; idle(p, 1'b0, "R9 mask unchanged irq low");
    idle(p, 1'b1, "R7 read");

    cmd(4'd2, 32'h0000_00F0, "R5 alt on");
    cmd(4'd7, 32'h0000_0030, "R3 rising polarity");
    cmd(4'd6, 32'h0000_00C0, "R3 falling polarity");
    p[7:4] = 4'h0; idle(p, 1'b0, "R3 falling only on falling-polarity pins");
    idle(p, 1'b1, "R3 read");
    p[7:4] = 4'hF; idle(p, 1'b0, "R3 rising only on rising-polarity pins");
    idle(p, 1'b1, "R3 read again");

    cmd(4'd2, 32'h0000_0003, "R4 alt on");
    cmd(4'd5, 32'h0000_0003, "R4 level kind");
    cmd(4'd7, 32'h0000_0001, "R4 high polarity");
    cmd(4'd6, 32'h0000_0002, "R4 low polarity");
    p[1:0] = 2'b11; idle(p, 1'b1, "R4 high level reported");
    idle(p, 1'b1, "R4 refire after read");
    p[1:0] = 2'b00; idle(p, 1'b1, "R4 low level reported");
    cmd(4'd3, 32'h0000_0003, "R4 alt off");
    idle(p, 1'b1, "R4 read");

    p[9] = ~p[9]; idle(p, 1'b1, "R6 event on read edge kept");
    idle(p, 1'b0, "R7 sticky");
    idle(p, 1'b0, "R7 sticky still");
    cmd(4'd1, 32'hFFFF_FFFF, "R8 mask off all");
    cmd(4'd0, 32'h0000_0200, "R8 mask on pin 9");
    idle(p, 1'b1, "R8 cleared");

    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] t;
      t = $urandom & $urandom & $urandom;
      p = p ^ t;
      if (($urandom % 4) == 0)
        step(p, 1'b1, 4'($urandom % 12), $urandom, ($urandom % 5) == 0, "R8 random");
      else
        step(p, 1'b0, 4'd0, '0, ($urandom % 5) == 0, "R7 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule